// File: doc/BRIEF.md
# Channel-hashed physical address composer

This block turns a normalized memory-channel address and a channel index into a 48-bit system physical address. The normalized address is split into a byte offset, which stays in the low byte, and an upper part, which is moved up to 32 KB block granularity. The 7-bit channel index sits between them at 256-byte granularity.

After that assembly, three channel-select bits (physical bits 12, 13 and 14) are not left as plain copies of the index. Each one becomes the XOR of a chosen index bit with a fixed set of higher address bits. Each of those address taps is enabled by one of five granularity enables (4K, 64K, 2M, 1G, 1T). A parameter selects either a purely combinational path or a path with one output register and a valid flag.

Top module: `chan_pa_compose`

## Requirements
- R1: `phys_addr_o[7:0]` equals `norm_addr_i[7:0]` unchanged.
- R2: `phys_addr_o[11:8]` equals `chan_idx_i[3:0]`; the full index is first placed at bits 14:8, so the address equals the index shifted left by 8.
- R3: `phys_addr_o[47:15]` equals `norm_addr_i[40:8]`, which is the normalized address with its low byte cleared and shifted left by 7.
- R4: Bit 12 equals chan_idx_i[5] XOR (p[20]&en64K) XOR (p[27]&en2M) XOR (p[34]&en1G) XOR (p[41]&en1T). Here p is the address before hashing.
- R5: Bit 13 equals chan_idx_i[6] XOR (p[21]&en64K) XOR (p[28]&en2M) XOR (p[35]&en1G) XOR (p[42]&en1T).
- R6: Bit 14 equals chan_idx_i[4] XOR (p[19]&en64K) XOR (p[26]&en2M) XOR (p[33]&en1G) XOR (p[40]&en1T) XOR (p[47]&en4K).
- R7: A tap whose enable is low has no effect. With `hash_en_i` all zero, bits 14:12 are {chan_idx_i[4], chan_idx_i[6], chan_idx_i[5]}.
- R8: `hash_en_i` is encoded as bit0=4K, bit1=64K, bit2=2M, bit3=1G and bit4=1T. The default setting, 5'b11110 (4K off, all others on), produces the hashes in R4 to R6.
- R9: With the output register present, `valid_o` follows `valid_i` one cycle later, and `phys_addr_o` shows the address of the accepted input. While reset is low, `valid_o` and `phys_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input qualifier |
| norm_addr_i | input | 41 | Normalized channel address |
| chan_idx_i | input | 7 | Channel index |
| hash_en_i | input | 5 | Granularity hash enables {1T,1G,2M,64K,4K} |
| valid_o | output | 1 | Output qualifier |
| phys_addr_o | output | 48 | Composed physical address |

## Verification
On every accepted input, the assertions check the fields that pass straight through: the offset, the low index bits and the block part. They also check the unhashed channel bits when every enable is low, and the one-cycle valid latency. The hash formulas with taps enabled can only be shown by the scoreboard scenarios: single enables, the 4K tap at bit 47, the default enable set, and mixed random patterns compared against an independent model.

// File: rtl/chan_pa_pkg.sv
package chan_pa_pkg;
  localparam int PA_W       = 48;
  localparam int BLK_LSB    = 15;              // 32 KB block
  localparam int OFF_W      = 8;               // 256 B block
  localparam int CH_W       = BLK_LSB - OFF_W; // 7
  localparam int NA_W       = PA_W - (BLK_LSB - OFF_W);
  localparam int HASH_LSB   = 12;
  localparam int NUM_HASH   = 3;
  localparam int NUM_GRAN   = 5;
  localparam int TAP_STRIDE = 7;

  // hash_en_i bit positions
  localparam int EN_4K = 0, EN_64K = 1, EN_2M = 2, EN_1G = 3, EN_1T = 4;
  localparam logic [NUM_GRAN-1:0] HASH_EN_DEFAULT = 5'b11110;

  // index bit feeding hash bit k (pa bits 12,13,14)
  function automatic int hash_idx_bit(int k);
    case (k)
      0: return 5;
      1: return 6;
      default: return 4;
    endcase
  endfunction

  // lowest (64K) address tap of hash bit k
  function automatic int hash_tap_base(int k);
    case (k)
      0: return 20;
      1: return 21;
      default: return 19;
    endcase
  endfunction

  // tap g sits at base + g*stride; g order 64K,2M,1G,1T,4K
  function automatic int gran_en_bit(int g);
    case (g)
      0: return EN_64K;
      1: return EN_2M;
      2: return EN_1G;
      3: return EN_1T;
      default: return EN_4K;
    endcase
  endfunction
endpackage

// File: rtl/pa_base_compose.sv
module pa_base_compose
  import chan_pa_pkg::*;
(
  input  logic [NA_W-1:0] norm_addr_i,
  input  logic [CH_W-1:0] chan_idx_i,
  output logic [PA_W-1:0] pre_pa_o
);
  // block part, index at 256 B, offset
  assign pre_pa_o = {norm_addr_i[NA_W-1:OFF_W], chan_idx_i, norm_addr_i[OFF_W-1:0]};
endmodule

// File: rtl/pa_chan_hash.sv
module pa_chan_hash
  import chan_pa_pkg::*;
(
  input  logic [PA_W-1:0]     pre_pa_i,
  input  logic [CH_W-1:0]     chan_idx_i,
  input  logic [NUM_GRAN-1:0] hash_en_i,
  output logic [NUM_HASH-1:0] hash_o
);
  logic [NUM_GRAN-1:0] term [NUM_HASH];

  for (genvar k = 0; k < NUM_HASH; k++) begin : g_bit
    localparam int BASE = hash_tap_base(k);
    for (genvar g = 0; g < NUM_GRAN; g++) begin : g_tap
      localparam int TAP = BASE + g * TAP_STRIDE;
      if (TAP < PA_W) begin : g_on
        assign term[k][g] = pre_pa_i[TAP] & hash_en_i[gran_en_bit(g)];
      end else begin : g_off
        assign term[k][g] = 1'b0;
      end
    end
    assign hash_o[k] = chan_idx_i[hash_idx_bit(k)] ^ (^term[k]);
  end
endmodule

// File: rtl/chan_pa_compose.sv
module chan_pa_compose
  import chan_pa_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [NA_W-1:0]     norm_addr_i,
  input  logic [CH_W-1:0]     chan_idx_i,
  input  logic [NUM_GRAN-1:0] hash_en_i,
  output logic                valid_o,
  output logic [PA_W-1:0]     phys_addr_o
);
  localparam int HASH_MSB = HASH_LSB + NUM_HASH - 1;

  logic [PA_W-1:0]     pre_pa, pa_d;
  logic [NUM_HASH-1:0] hash;

  pa_base_compose i_base (
    .norm_addr_i (norm_addr_i),
    .chan_idx_i  (chan_idx_i),
    .pre_pa_o    (pre_pa)
  );

  // taps read bits >= 19 only, so all hashes use the pre-hash address
  pa_chan_hash i_hash (
    .pre_pa_i   (pre_pa),
    .chan_idx_i (chan_idx_i),
    .hash_en_i  (hash_en_i),
    .hash_o     (hash)
  );

  assign pa_d = {pre_pa[PA_W-1:HASH_MSB+1], hash, pre_pa[HASH_LSB-1:0]};

  if (REG_OUT) begin : g_reg
    logic            vld_q;
    logic [PA_W-1:0] pa_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        pa_q  <= '0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) pa_q <= pa_d;
      end
    end

    assign valid_o     = vld_q;
    assign phys_addr_o = pa_q;

    assert_offset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> phys_addr_o[OFF_W-1:0] == $past(norm_addr_i[OFF_W-1:0]));
    assert_idx_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> phys_addr_o[HASH_LSB-1:OFF_W] == $past(chan_idx_i[HASH_LSB-OFF_W-1:0]));
    assert_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> phys_addr_o[PA_W-1:BLK_LSB] == $past(norm_addr_i[NA_W-1:OFF_W]));
    assert_no_hash_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && hash_en_i == '0) |=>
        phys_addr_o[HASH_MSB:HASH_LSB] == {$past(chan_idx_i[4]), $past(chan_idx_i[6]), $past(chan_idx_i[5])});
    assert_valid_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    assert_valid_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(phys_addr_o));
  end else begin : g_comb
    assign valid_o     = valid_i;
    assign phys_addr_o = pa_d;
  end
endmodule

// File: tb/test_chan_pa_compose.sv
module test_chan_pa_compose;
  import chan_pa_pkg::*;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                valid_i = 1'b0;
  logic [NA_W-1:0]     norm_addr_i = '0;
  logic [CH_W-1:0]     chan_idx_i = '0;
  logic [NUM_GRAN-1:0] hash_en_i = '0;
  logic                valid_o;
  logic [PA_W-1:0]     phys_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [PA_W-1:0] exp_q[$];
  string           tag_q[$];

  always #5 clk_i = ~clk_i;

  chan_pa_compose i_chan_pa_compose (.*);

  function automatic logic [PA_W-1:0] model(logic [NA_W-1:0] na, logic [CH_W-1:0] ix,
                                            logic [NUM_GRAN-1:0] en);
    logic [PA_W-1:0] p;
    logic c4, c5, c6;
    p  = ((PA_W'(na) & ~PA_W'(48'hff)) << 7) | (PA_W'(ix) << 8) | (PA_W'(na) & PA_W'(48'hff));
    c4 = ix[5] ^ (p[20]&en[1]) ^ (p[27]&en[2]) ^ (p[34]&en[3]) ^ (p[41]&en[4]);
    c5 = ix[6] ^ (p[21]&en[1]) ^ (p[28]&en[2]) ^ (p[35]&en[3]) ^ (p[42]&en[4]);
    c6 = ix[4] ^ (p[19]&en[1]) ^ (p[26]&en[2]) ^ (p[33]&en[3]) ^ (p[40]&en[4]) ^ (p[47]&en[0]);
    p[14:12] = {c6, c5, c4};
    return p;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [NA_W-1:0] na, logic [CH_W-1:0] ix, logic [NUM_GRAN-1:0] en, string tag);
    @(negedge clk_i);
    valid_i = 1'b1; norm_addr_i = na; chan_idx_i = ix; hash_en_i = en;
    exp_q.push_back(model(na, ix, en));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      norm_addr_i = NA_W'($urandom()); // must not disturb held output
    end
  endtask

  // monitor: sample 1 ns after the edge that loads the output register
  initial begin
    forever begin
      @(posedge clk_i); #1;
      if (rst_ni) begin
        check("R9 valid latency", 64'(valid_o), 64'(valid_i));
        if (valid_o) begin
          if (exp_q.size() == 0) check("R9 unexpected output", 64'd1, 64'd0);
          else begin
            logic [PA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({"R1 offset ", t}, 64'(phys_addr_o[7:0]), 64'(e[7:0]));
            check({"R2 index ", t}, 64'(phys_addr_o[11:8]), 64'(e[11:8]));
            check({"R3 block ", t}, 64'(phys_addr_o[47:15]), 64'(e[47:15]));
            check({"R4 ch bit12 ", t}, 64'(phys_addr_o[12]), 64'(e[12]));
            check({"R5 ch bit13 ", t}, 64'(phys_addr_o[13]), 64'(e[13]));
            check({"R6 ch bit14 ", t}, 64'(phys_addr_o[14]), 64'(e[14]));
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset valid", 64'(valid_o), 64'd0);
    check("R9 reset addr", 64'(phys_addr_o), 64'd0);
    rst_ni = 1'b1;

    drive('0, '0, HASH_EN_DEFAULT, "zero");
    drive('1, 7'h7f, HASH_EN_DEFAULT, "ones R8");
    drive(41'h0AB_CDEF_1234, 7'h35, 5'b00000, "R7 all off");
    drive(41'h155_5555_5555, 7'h70, 5'b00000, "R7 all off idx hi");
    idle(2);
    drive(41'h100_0000_0000, 7'h00, 5'b00001, "R6 4K tap");
    drive(41'h100_0000_0000, 7'h00, 5'b11110, "R7 4K off");
    for (int g = 0; g < NUM_GRAN; g++)
      for (int r = 0; r < 4; r++)
        drive(NA_W'({$urandom(), $urandom()}), CH_W'($urandom()), NUM_GRAN'(1 << g), "R7 single enable");
    idle(1);
    for (int r = 0; r < 10; r++)
      drive(NA_W'({$urandom(), $urandom()}), CH_W'($urandom()), HASH_EN_DEFAULT, "R8 default");
    for (int r = 0; r < 40; r++) begin
      drive(NA_W'({$urandom(), $urandom()}), CH_W'($urandom()), NUM_GRAN'($urandom()), "mixed");
      if (r % 7 == 3) idle(1);
    end
    idle(3);
    check("R9 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule